// File: doc/BRIEF.md
# Secure Button and Passphrase Entry Controller

This block is the trusted front end for installing and clearing secrets. Two push buttons come in raw from the board. One button wipes the device key. The other either starts passphrase entry or wipes the user key, depending on whether a user key is currently held. Each button is filtered by a stable-count debouncer and acts once per press. Two three-colour LEDs show whether each key register holds a value.

During secure entry the decrypted keystroke bytes are not passed on to the system. Each byte goes to an external hash engine through a start / byte / end / done handshake. A carriage return closes the entry, and the digest returned by the engine becomes the user key. Outside secure entry, keystrokes flow straight through to a normal output stream.

The keystroke input is a valid/ready stream. A byte moves when `key_valid` and `key_ready` are both high at a clock edge, and `key_byte` must stay stable while `key_valid` waits. Outside secure entry, `key_ready` follows `pass_ready`, so back-pressure comes from the downstream consumer. During entry the block is always ready except in the cycle an Authenticate press is taken. While it waits for the digest, `key_ready` is held low. The hash engine must accept one byte in every cycle that `hash_byte_valid` is high.

Top module: `trusted_entry_ctrl`

## Requirements
- R1: Each raw button passes through two synchroniser flops. The filtered level changes only after the synchronised input has differed from it for DEB_CYCLES consecutive clocks. A filtered rising edge gives exactly one single-cycle press, and a pulse shorter than DEB_CYCLES clocks has no effect.
- R2: A Device Reset press clears `dev_key` to zero. A write on `dev_key_wr` stores `dev_key_wdata`. When the press and the write fall in the same cycle, the clear wins.
- R3: `led_dev` is 3'b001 (bit 0 red) while `dev_key` is zero and 3'b100 (bit 2 blue) otherwise.
- R4: An Authenticate press while `user_key` is zero keeps `user_key` at zero. It then raises `hash_start` for exactly one cycle, and secure entry follows.
- R5: In secure entry every accepted byte other than 0x0D appears on `hash_byte` with `hash_byte_valid` high, in arrival order. `key_ready` is high, and `pass_valid` stays low.
- R6: An accepted 0x0D after at least one hashed byte raises `hash_end` in that cycle and is not hashed. `key_ready` then stays low until `hash_done`, which loads `hash_digest` into `user_key`.
- R7: `led_auth` is 3'b001 (red) while `user_key` is zero and 3'b010 (bit 1 green) otherwise.
- R8: An Authenticate press while `user_key` is non-zero sets it to zero and does not start entry.
- R9: Outside secure entry and the digest wait, `pass_valid` equals `key_valid` and `pass_byte` equals `key_byte`. `key_ready` equals `pass_ready`, and `hash_byte_valid` and `hash_end` stay low.
- R10: A 0x0D received as the first byte of an entry ends it with no `hash_end`. The block returns to pass-through, and `user_key` stays zero.
- R11: An Authenticate press during entry or during the digest wait aborts back to pass-through, with `user_key` zero. In that cycle `key_ready`, `hash_byte_valid` and `hash_end` are low, and a `hash_done` in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_dev_raw | input | 1 | Raw Device Reset button, high when pressed |
| btn_auth_raw | input | 1 | Raw Authenticate button, high when pressed |
| dev_key_wr | input | 1 | Installation write strobe for the device key |
| dev_key_wdata | input | KEY_W | Device key value to write |
| dev_key | output | KEY_W | Device key register |
| key_valid | input | 1 | Keystroke byte valid |
| key_ready | output | 1 | Keystroke byte accepted |
| key_byte | input | BYTE_W | Decrypted keystroke byte |
| pass_valid | output | 1 | Normal keystroke output valid |
| pass_ready | input | 1 | Normal keystroke consumer ready |
| pass_byte | output | BYTE_W | Normal keystroke output byte |
| hash_start | output | 1 | One-cycle pulse that starts a new digest |
| hash_byte_valid | output | 1 | Byte for the hash engine in this cycle |
| hash_byte | output | BYTE_W | Byte for the hash engine |
| hash_end | output | 1 | Final byte has been sent; engine may finish |
| hash_done | input | 1 | Digest ready, one cycle |
| hash_digest | input | KEY_W | Digest from the hash engine |
| user_key | output | KEY_W | User key register |
| led_dev | output | 3 | Device LED, bit 0 red, bit 1 green, bit 2 blue |
| led_auth | output | 3 | Authenticate LED, same colour bits |

## Verification
An Authenticate press can land in the same cycle as the carriage return that would close entry, or as the `hash_done` that would load the digest. A Device Reset press can also meet an installation write. The bench holds the raw button high for exactly the synchroniser-plus-filter latency and then presents the competing event in the cycle the filtered press is live. The cycle reference model, the ready and end pulses seen in that cycle, and a zero `user_key` or `dev_key` afterwards decide whether the abort or clear won.

// File: rtl/tec_pkg.sv
`timescale 1ns/1ps
package tec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_CAPT  = 2'd2,
    ST_WAIT  = 2'd3
  } cap_state_t;

  localparam logic [2:0] RGB_RED   = 3'b001;
  localparam logic [2:0] RGB_GREEN = 3'b010;
  localparam logic [2:0] RGB_BLUE  = 3'b100;

  localparam logic [7:0] CODE_CR = 8'h0D;
endpackage

// File: rtl/tec_debounce.sv
`timescale 1ns/1ps
module tec_debounce #(
  parameter int STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic press_o
);
  localparam int CW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic sync_a, sync_b, level;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a  <= 1'b0;
      sync_b  <= 1'b0;
      level   <= 1'b0;
      run     <= '0;
      press_o <= 1'b0;
    end else begin
      sync_a  <= raw_in;
      sync_b  <= sync_a;
      press_o <= 1'b0;
      if (sync_b == level) begin
        run <= '0;
      end else if (run == LAST) begin
        level   <= sync_b;
        run     <= '0;
        press_o <= sync_b;
      end else begin
        run <= run + CW'(1);
      end
    end
  end
endmodule

// File: rtl/tec_led.sv
`timescale 1ns/1ps
module tec_led #(
  parameter int         KEY_W      = 128,
  parameter logic [2:0] EMPTY_RGB  = 3'b001,
  parameter logic [2:0] LOADED_RGB = 3'b010
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [2:0]       rgb_o
);
  assign rgb_o = (|key_i) ? LOADED_RGB : EMPTY_RGB;
endmodule

// File: rtl/tec_capture.sv
`timescale 1ns/1ps
module tec_capture
  import tec_pkg::*;
#(
  parameter int KEY_W  = 128,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auth_press,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [BYTE_W-1:0] key_byte,
  output logic              pass_valid,
  input  logic              pass_ready,
  output logic [BYTE_W-1:0] pass_byte,
  output logic              hash_start,
  output logic              hash_byte_valid,
  output logic [BYTE_W-1:0] hash_byte,
  output logic              hash_end,
  input  logic              hash_done,
  input  logic [KEY_W-1:0]  hash_digest,
  output logic [KEY_W-1:0]  user_key
);
  localparam logic [BYTE_W-1:0] END_CODE = BYTE_W'(CODE_CR);

  cap_state_t st;
  logic       got_byte;
  logic       in_idle, in_capt, is_end, take;

  assign in_idle = (st == ST_IDLE);
  assign in_capt = (st == ST_CAPT);
  assign is_end  = (key_byte == END_CODE);
  assign take    = in_capt && !auth_press && key_valid;

  always_comb begin
    key_ready       = in_idle ? pass_ready : (in_capt && !auth_press);
    pass_valid      = in_idle && key_valid;
    pass_byte       = key_byte;
    hash_start      = (st == ST_START);
    hash_byte_valid = take && !is_end;
    hash_byte       = key_byte;
    hash_end        = take && is_end && got_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      got_byte <= 1'b0;
      user_key <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (auth_press) begin
            user_key <= '0;
            if (user_key == '0) begin
              st       <= ST_START;
              got_byte <= 1'b0;
            end
          end
        end
        ST_START: st <= auth_press ? ST_IDLE : ST_CAPT;
        ST_CAPT: begin
          if (auth_press) begin
            st <= ST_IDLE;
          end else if (key_valid) begin
            if (is_end) st <= got_byte ? ST_WAIT : ST_IDLE;
            else        got_byte <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (auth_press) begin
            st <= ST_IDLE;
          end else if (hash_done) begin
            user_key <= hash_digest;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trusted_entry_ctrl.sv
`timescale 1ns/1ps
module trusted_entry_ctrl
  import tec_pkg::*;
#(
  parameter int DEB_CYCLES = 50000,
  parameter int KEY_W      = 128,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_dev_raw,
  input  logic              btn_auth_raw,
  input  logic              dev_key_wr,
  input  logic [KEY_W-1:0]  dev_key_wdata,
  output logic [KEY_W-1:0]  dev_key,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [BYTE_W-1:0] key_byte,
  output logic              pass_valid,
  input  logic              pass_ready,
  output logic [BYTE_W-1:0] pass_byte,
  output logic              hash_start,
  output logic              hash_byte_valid,
  output logic [BYTE_W-1:0] hash_byte,
  output logic              hash_end,
  input  logic              hash_done,
  input  logic [KEY_W-1:0]  hash_digest,
  output logic [KEY_W-1:0]  user_key,
  output logic [2:0]        led_dev,
  output logic [2:0]        led_auth
);
  localparam int N_BTN    = 2;
  localparam int IDX_DEV  = 0;
  localparam int IDX_AUTH = 1;

  logic [N_BTN-1:0] raw_vec, press_vec;
  logic dev_press, auth_press;

  assign raw_vec[IDX_DEV]  = btn_dev_raw;
  assign raw_vec[IDX_AUTH] = btn_auth_raw;

  for (genvar g = 0; g < N_BTN; g++) begin : g_btn
    tec_debounce #(.STABLE_CYCLES(DEB_CYCLES)) u_db (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_in  (raw_vec[g]),
      .press_o (press_vec[g])
    );
  end

  assign dev_press  = press_vec[IDX_DEV];
  assign auth_press = press_vec[IDX_AUTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dev_key <= '0;
    else if (dev_press)  dev_key <= '0;
    else if (dev_key_wr) dev_key <= dev_key_wdata;
  end

  tec_capture #(.KEY_W(KEY_W), .BYTE_W(BYTE_W)) u_cap (
    .clk             (clk),
    .rst_n           (rst_n),
    .auth_press      (auth_press),
    .key_valid       (key_valid),
    .key_ready       (key_ready),
    .key_byte        (key_byte),
    .pass_valid      (pass_valid),
    .pass_ready      (pass_ready),
    .pass_byte       (pass_byte),
    .hash_start      (hash_start),
    .hash_byte_valid (hash_byte_valid),
    .hash_byte       (hash_byte),
    .hash_end        (hash_end),
    .hash_done       (hash_done),
    .hash_digest     (hash_digest),
    .user_key        (user_key)
  );

  tec_led #(.KEY_W(KEY_W), .EMPTY_RGB(RGB_RED), .LOADED_RGB(RGB_BLUE)) u_led_dev (
    .key_i (dev_key),
    .rgb_o (led_dev)
  );

  tec_led #(.KEY_W(KEY_W), .EMPTY_RGB(RGB_RED), .LOADED_RGB(RGB_GREEN)) u_led_auth (
    .key_i (user_key),
    .rgb_o (led_auth)
  );
endmodule

// File: rtl/trusted_entry_chk.sv
`timescale 1ns/1ps
module trusted_entry_chk #(
  parameter int KEY_W  = 128,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_press,
  input logic              auth_press,
  input logic [KEY_W-1:0]  dev_key,
  input logic [KEY_W-1:0]  user_key,
  input logic [2:0]        led_dev,
  input logic [2:0]        led_auth,
  input logic              key_ready,
  input logic              pass_valid,
  input logic              hash_start,
  input logic              hash_byte_valid,
  input logic [BYTE_W-1:0] hash_byte,
  input logic              hash_end
);
  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_press |=> !dev_press); // R1
  AST_DEV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dev_press |=> dev_key == '0); // R2
  AST_DEV_LED: assert property (@(posedge clk) disable iff (!rst_n)
    (led_dev == 3'b001) == (dev_key == '0)); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> !hash_start); // R4
  AST_NO_CR_HASHED: assert property (@(posedge clk) disable iff (!rst_n)
    hash_byte_valid |-> hash_byte != BYTE_W'(8'h0D)); // R5
  AST_WAIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    hash_end |=> !key_ready); // R6
  AST_AUTH_LED: assert property (@(posedge clk) disable iff (!rst_n)
    (led_auth == 3'b010) == (user_key != '0)); // R7
  AST_ZEROISE: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_press && user_key != '0) |=> user_key == '0); // R8
  AST_PASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> (!hash_byte_valid && !hash_end)); // R9
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    auth_press |-> (!hash_byte_valid && !hash_end)); // R11
endmodule

bind trusted_entry_ctrl trusted_entry_chk #(.KEY_W(KEY_W), .BYTE_W(BYTE_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .dev_press       (dev_press),
  .auth_press      (auth_press),
  .dev_key         (dev_key),
  .user_key        (user_key),
  .led_dev         (led_dev),
  .led_auth        (led_auth),
  .key_ready       (key_ready),
  .pass_valid      (pass_valid),
  .hash_start      (hash_start),
  .hash_byte_valid (hash_byte_valid),
  .hash_byte       (hash_byte),
  .hash_end        (hash_end)
);

// File: tb/trusted_entry_ctrl_test.sv
`timescale 1ns/1ps
module trusted_entry_ctrl_test;
  localparam int DEB = 4;
  localparam int KW  = 128;
  localparam int BW  = 8;
  localparam logic [KW-1:0] INIT = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, dev_raw = 1'b0, auth_raw = 1'b0, dev_wr = 1'b0;
  logic [KW-1:0] dev_wdata = '0, hash_digest = '0;
  logic key_valid = 1'b0, pass_ready = 1'b1, hash_done = 1'b0;
  logic [BW-1:0] key_byte = '0;
  logic [KW-1:0] dev_key, user_key;
  logic key_ready, pass_valid, hash_start, hash_byte_valid, hash_end;
  logic [BW-1:0] pass_byte, hash_byte;
  logic [2:0] led_dev, led_auth;

  trusted_entry_ctrl #(.DEB_CYCLES(DEB), .KEY_W(KW), .BYTE_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .btn_dev_raw(dev_raw), .btn_auth_raw(auth_raw),
    .dev_key_wr(dev_wr), .dev_key_wdata(dev_wdata), .dev_key(dev_key),
    .key_valid(key_valid), .key_ready(key_ready), .key_byte(key_byte),
    .pass_valid(pass_valid), .pass_ready(pass_ready), .pass_byte(pass_byte),
    .hash_start(hash_start), .hash_byte_valid(hash_byte_valid), .hash_byte(hash_byte),
    .hash_end(hash_end), .hash_done(hash_done), .hash_digest(hash_digest),
    .user_key(user_key), .led_dev(led_dev), .led_auth(led_auth));

  int n_chk = 0, n_err = 0;
  bit done_flag = 1'b0;

  task automatic expect_eq(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [KW-1:0] mix(input logic [KW-1:0] acc, input logic [7:0] b);
    return {acc[KW-9:0], acc[KW-1:KW-8] ^ b};
  endfunction

  function automatic logic [KW-1:0] exp_digest(input string s);
    logic [KW-1:0] a = INIT;
    for (int i = 0; i < s.len(); i++) a = mix(a, s[i]);
    return a;
  endfunction

  // ---------------- reference model (behavioural, cycle based) ----------------
  localparam int M_IDLE = 0, M_START = 1, M_CAPT = 2, M_WAIT = 3;
  int m_st = M_IDLE;
  bit m_got = 0;
  logic [KW-1:0] m_uk = '0, m_dk = '0;
  bit m_s1 [2], m_s2 [2], m_lvl [2], m_prs [2];
  int m_run [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_got = 0; m_uk = '0; m_dk = '0;
      for (int i = 0; i < 2; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_lvl[i] = 0; m_prs[i] = 0; m_run[i] = 0;
      end
    end else begin
      case (m_st)
        M_IDLE: if (m_prs[1]) begin
          if (m_uk != '0) m_uk = '0;
          else begin m_st = M_START; m_got = 0; end
        end
        M_START: m_st = m_prs[1] ? M_IDLE : M_CAPT;
        M_CAPT: begin
          if (m_prs[1]) m_st = M_IDLE;
          else if (key_valid) begin
            if (key_byte == 8'h0D) m_st = m_got ? M_WAIT : M_IDLE;
            else m_got = 1;
          end
        end
        default: begin
          if (m_prs[1]) m_st = M_IDLE;
          else if (hash_done) begin m_uk = hash_digest; m_st = M_IDLE; end
        end
      endcase
      if (m_prs[0]) m_dk = '0;
      else if (dev_wr) m_dk = dev_wdata;
      for (int i = 0; i < 2; i++) begin
        m_prs[i] = 0;
        if (m_s2[i] != m_lvl[i]) begin
          m_run[i]++;
          if (m_run[i] == DEB) begin
            m_lvl[i] = m_s2[i]; m_run[i] = 0; m_prs[i] = m_lvl[i];
          end
        end else m_run[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = (i == 0) ? dev_raw : auth_raw;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      logic e_idle, e_capt, e_take, e_rdy;
      e_idle = (m_st == M_IDLE);
      e_capt = (m_st == M_CAPT);
      e_take = e_capt && !m_prs[1] && key_valid;
      e_rdy  = e_idle ? pass_ready : (e_capt && !m_prs[1]);
      expect_eq("R9 key_ready", KW'(key_ready), KW'(e_rdy));
      expect_eq("R9 pass_valid", KW'(pass_valid), KW'(e_idle && key_valid));
      if (pass_valid) expect_eq("R9 pass_byte", KW'(pass_byte), KW'(key_byte));
      expect_eq("R4 hash_start", KW'(hash_start), KW'(m_st == M_START));
      expect_eq("R5 hash_byte_valid", KW'(hash_byte_valid), KW'(e_take && key_byte != 8'h0D));
      if (hash_byte_valid) expect_eq("R5 hash_byte", KW'(hash_byte), KW'(key_byte));
      expect_eq("R6 hash_end", KW'(hash_end), KW'(e_take && key_byte == 8'h0D && m_got));
      expect_eq("R6 user_key", user_key, m_uk);
      expect_eq("R2 dev_key", dev_key, m_dk);
      expect_eq("R3 led_dev", KW'(led_dev), KW'((m_dk == '0) ? 3'b001 : 3'b100));
      expect_eq("R7 led_auth", KW'(led_auth), KW'((m_uk == '0) ? 3'b001 : 3'b010));
    end
  end

  // ---------------- hash engine stand-in ----------------
  logic [KW-1:0] eng_acc = INIT;
  int eng_cd = 0, man_req = 0, man_seen = 0, n_start = 0, n_end = 0;
  bit eng_auto = 1;

  always @(negedge clk) begin
    hash_done = 1'b0;
    if (hash_start) begin eng_acc = INIT; n_start++; end
    if (hash_byte_valid) eng_acc = mix(eng_acc, hash_byte);
    if (hash_end) begin
      n_end++;
      if (eng_auto) eng_cd = 3;
    end else if (eng_cd > 0) begin
      eng_cd--;
      if (eng_cd == 0) begin hash_done = 1'b1; hash_digest = eng_acc; end
    end
    if (man_req != man_seen) begin
      man_seen = man_req; hash_done = 1'b1; hash_digest = eng_acc ^ 128'h5A;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_btn(input int which, input logic v);
    if (which == 0) dev_raw = v; else auth_raw = v;
  endtask

  task automatic press(input int which);
    drive_btn(which, 1'b1); cyc(DEB + 4);
    drive_btn(which, 1'b0); cyc(DEB + 4);
  endtask

  task automatic send_byte(input logic [7:0] b);
    key_byte = b; key_valid = 1'b1;
    do @(negedge clk); while (!key_ready);
    @(posedge clk); #1;
    key_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) begin
      send_byte(s[i]);
      if (i == 0) cyc(2);
    end
    send_byte(8'h0D);
  endtask

  task automatic summary;
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    cyc(150000);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int s0;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    expect_eq("R3 reset led_dev", KW'(led_dev), KW'(3'b001));
    expect_eq("R7 reset led_auth", KW'(led_auth), KW'(3'b001));
    expect_eq("R6 reset user_key", user_key, '0);
    expect_eq("R2 reset dev_key", dev_key, '0);

    // R9 pass-through and back-pressure
    send_byte(8'h41); send_byte(8'h0D);
    pass_ready = 1'b0; key_byte = 8'h55; key_valid = 1'b1;
    @(negedge clk);
    expect_eq("R9 stall key_ready", KW'(key_ready), KW'(0));
    @(posedge clk); #1;
    key_valid = 1'b0; pass_ready = 1'b1;

    // R3 / R2 device key
    dev_wr = 1'b1; dev_wdata = 128'hC0FFEE00112233445566778899AABBCC; cyc(1); dev_wr = 1'b0;
    expect_eq("R3 led_dev blue", KW'(led_dev), KW'(3'b100));
    press(0);
    expect_eq("R2 clear dev_key", dev_key, '0);
    dev_wr = 1'b1; dev_wdata = 128'h1; cyc(1); dev_wr = 1'b0;
    drive_btn(0, 1'b1); cyc(DEB + 2);
    dev_wr = 1'b1; dev_wdata = 128'hBEEF; cyc(1); dev_wr = 1'b0;
    expect_eq("R2 clear beats write", dev_key, '0);
    drive_btn(0, 1'b0); cyc(DEB + 4);

    // R4 / R5 / R6 / R7 capture
    s0 = n_start;
    press(1);
    expect_eq("R4 one start", KW'(n_start), KW'(s0 + 1));
    send_str("Ab3x"); cyc(8);
    expect_eq("R6 digest loaded", user_key, exp_digest("Ab3x"));
    expect_eq("R7 led_auth green", KW'(led_auth), KW'(3'b010));

    // R9 bytes while loaded are not hashed
    s0 = n_end; send_byte(8'h7A); cyc(4);
    expect_eq("R9 no hash while idle", KW'(n_end), KW'(s0));

    // R1 short glitch ignored
    auth_raw = 1'b1; cyc(DEB - 1); auth_raw = 1'b0; cyc(DEB + 6);
    expect_eq("R1 glitch ignored", user_key, exp_digest("Ab3x"));

    // R8 zeroise
    press(1);
    expect_eq("R8 zeroised", user_key, '0);
    expect_eq("R8 led red", KW'(led_auth), KW'(3'b001));

    // R10 empty passphrase
    s0 = n_end;
    press(1); send_byte(8'h0D); cyc(6);
    expect_eq("R10 no hash_end", KW'(n_end), KW'(s0));
    expect_eq("R10 key zero", user_key, '0);
    send_byte(8'h70);

    // R11 press meets carriage return
    s0 = n_end;
    press(1); send_byte(8'h71);
    auth_raw = 1'b1; cyc(DEB + 2);
    key_byte = 8'h0D; key_valid = 1'b1;
    @(negedge clk);
    expect_eq("R11 ready low on press", KW'(key_ready), KW'(0));
    expect_eq("R11 no end on press", KW'(hash_end), KW'(0));
    cyc(1); cyc(1); key_valid = 1'b0;
    auth_raw = 1'b0; cyc(DEB + 4);
    expect_eq("R11 aborted key zero", user_key, '0);
    expect_eq("R11 no hash_end", KW'(n_end), KW'(s0));

    // R11 press meets hash_done
    eng_auto = 0;
    press(1); send_str("k9"); cyc(2);
    auth_raw = 1'b1; cyc(DEB + 2);
    man_req++;
    cyc(2); auth_raw = 1'b0; cyc(DEB + 4);
    expect_eq("R11 done discarded", user_key, '0);

    // recovery capture
    eng_auto = 1;
    press(1); send_str("Zz"); cyc(8);
    expect_eq("R6 second digest", user_key, exp_digest("Zz"));
    cyc(4);
    summary();
  end
endmodule